// File: doc/BRIEF.md
# Shift-and-Add Address Generation Unit

This block executes the address-generation group of bit-manipulation instructions on a 64-bit datapath. Each operation takes an index from the first source and a base from the second source. The index is scaled by a fixed left shift of 1, 2 or 3, and the sum is the result. The unsigned-word forms first zero-extend the low 32 bits of the index. A shift-immediate form zero-extends the low word and then shifts it left by a 6-bit amount. A runtime enable bit from the machine ISA register can switch the whole group off. While the bit is clear, every operation reports an illegal instruction and produces no result.

Operations arrive on a valid/ready input stream and leave on a valid/ready output stream. A single output register separates the two streams. The unit accepts a new operation whenever that register is empty, or when the register is being drained in the same cycle. While the consumer holds `out_ready` low with `out_valid` high, the held result and flag do not change, and `in_ready` stays low. The enable bit is a plain control pin, sampled together with the accepted operation.

Top module: `agu_shadd_unit`

## Requirements
- R1: Opcodes 3'b001, 3'b010 and 3'b011 (scaled add by 1, 2, 3) produce `in_src2 + (in_src1 << N)`, where N is `in_op[1:0]`.
- R2: Opcodes 3'b101, 3'b110 and 3'b111 (unsigned-word scaled add) zero-extend `in_src1[31:0]` to 64 bits before the shift by N = `in_op[1:0]`, then add `in_src2`. Bits 63:32 of `in_src1` never reach the result.
- R3: Opcode 3'b100 (unsigned-word add) produces `{32'b0, in_src1[31:0]} + in_src2`. With `in_src2` zero, this is the zero-extended low word of `in_src1`.
- R4: Opcode 3'b000 (unsigned-word immediate shift) produces `{32'b0, in_src1[31:0]} << in_shamt` for any amount from 0 to 63. It ignores `in_src2`. Every other opcode ignores `in_shamt`.
- R5: All additions wrap modulo 2^64, and no overflow indication exists.
- R6: An operation accepted while `bm_enable` is 0 comes out with `out_illegal` = 1 and `out_result` = 0.
- R7: An operation accepted while `bm_enable` is 1 comes out with `out_illegal` = 0.
- R8: `in_ready` is 1 exactly when the output register is empty or `out_ready` is 1. An operation transfers on a cycle with both `in_valid` and `in_ready` high, and it appears on the outputs from the next cycle.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_result` and `out_illegal` hold their values.
- R10: After reset, `out_valid`, `out_illegal` and `out_result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 3 | Operation select: bit 2 selects the unsigned-word index, bits 1:0 give the scale |
| in_src1 | input | 64 | Index operand |
| in_src2 | input | 64 | Base operand |
| in_shamt | input | 6 | Shift amount for the immediate-shift opcode |
| bm_enable | input | 1 | Bit-manipulation enable from the machine ISA register |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_result | output | 64 | Computed address, or zero when illegal |
| out_illegal | output | 1 | Operation must trap as an illegal instruction |

## Verification
The assertions check the stream rules on every cycle:
- back-pressure blocks the input;
- a stalled output holds its values;
- an illegal result is always zero;
- the enable bit maps to the illegal flag.

One assertion also recomputes the unsigned-word scaled add against the operands of the previous cycle. The arithmetic of the other opcodes is shown only by the bench's scenarios:
- the exact sums;
- modulo wraparound;
- that the high word of the index is discarded;
- the full range of immediate shifts;
- that `in_shamt` and `in_src2` have no effect where they do not apply.

// File: rtl/agu_pkg.sv
package agu_pkg;

  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SLLI_UW   = 3'b000,
    OP_SH1ADD    = 3'b001,
    OP_SH2ADD    = 3'b010,
    OP_SH3ADD    = 3'b011,
    OP_ADD_UW    = 3'b100,
    OP_SH1ADD_UW = 3'b101,
    OP_SH2ADD_UW = 3'b110,
    OP_SH3ADD_UW = 3'b111
  } agu_op_e;

  typedef struct packed {
    logic       zext_index;
    logic [1:0] scale;
    logic       use_base;
    logic       imm_shift;
  } agu_ctl_t;

  function automatic agu_ctl_t agu_decode(input logic [OP_W-1:0] op);
    agu_ctl_t c;
    c.imm_shift  = (op == OP_SLLI_UW);
    c.zext_index = op[2] | c.imm_shift;
    c.scale      = op[1:0];
    c.use_base   = !c.imm_shift;
    return c;
  endfunction

endpackage

// File: rtl/agu_index_prep.sv
module agu_index_prep
  import agu_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SH_W   = $clog2(XLEN)
) (
  input  agu_ctl_t              ctl,
  input  logic [XLEN-1:0]       src,
  input  logic [SH_W-1:0]       shamt,
  output logic [XLEN-1:0]       index
);

  logic [XLEN-1:0] narrowed;

  generate
    if (XLEN > WORD_W) begin : g_zext
      always_comb begin
        narrowed = src;
        if (ctl.zext_index) narrowed[XLEN-1:WORD_W] = '0;
      end
    end else begin : g_nozext
      always_comb narrowed = src;
    end
  endgenerate

  always_comb begin
    if (ctl.imm_shift) index = narrowed << shamt;
    else               index = narrowed << ctl.scale;
  end

endmodule

// File: rtl/agu_adder.sv
module agu_adder #(
  parameter int unsigned XLEN = 64
) (
  input  logic            use_base,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] index,
  output logic [XLEN-1:0] sum
);

  logic [XLEN-1:0] gated_base;

  always_comb begin
    gated_base = use_base ? base : '0;
    sum        = gated_base + index;
  end

endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up_valid,
  output logic            up_ready,
  input  logic [XLEN-1:0] up_result,
  input  logic            up_illegal,
  output logic            dn_valid,
  input  logic            dn_ready,
  output logic [XLEN-1:0] dn_result,
  output logic            dn_illegal
);

  logic take;

  always_comb begin
    up_ready = !dn_valid || dn_ready;
    take     = up_valid && up_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid   <= 1'b0;
      dn_result  <= '0;
      dn_illegal <= 1'b0;
    end else if (take) begin
      dn_valid   <= 1'b1;
      dn_result  <= up_illegal ? '0 : up_result;
      dn_illegal <= up_illegal;
    end else if (dn_ready) begin
      dn_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/agu_shadd_unit.sv
module agu_shadd_unit
  import agu_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned WORD_W     = 32,
  parameter bit          BM_PRESENT = 1'b1,
  localparam int unsigned SH_W      = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [XLEN-1:0]   in_src1,
  input  logic [XLEN-1:0]   in_src2,
  input  logic [SH_W-1:0]   in_shamt,
  input  logic              bm_enable,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_result,
  output logic              out_illegal
);

  agu_ctl_t        ctl;
  logic [XLEN-1:0] index;
  logic [XLEN-1:0] sum;
  logic            illegal;

  always_comb ctl = agu_decode(in_op);

  generate
    if (BM_PRESENT) begin : g_gate
      always_comb illegal = !bm_enable;
    end else begin : g_absent
      always_comb illegal = 1'b1;
    end
  endgenerate

  agu_index_prep #(.XLEN(XLEN), .WORD_W(WORD_W), .SH_W(SH_W)) u_prep (
    .ctl   (ctl),
    .src   (in_src1),
    .shamt (in_shamt),
    .index (index)
  );

  agu_adder #(.XLEN(XLEN)) u_add (
    .use_base (ctl.use_base),
    .base     (in_src2),
    .index    (index),
    .sum      (sum)
  );

  agu_out_stage #(.XLEN(XLEN)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_valid   (in_valid),
    .up_ready   (in_ready),
    .up_result  (sum),
    .up_illegal (illegal),
    .dn_valid   (out_valid),
    .dn_ready   (out_ready),
    .dn_result  (out_result),
    .dn_illegal (out_illegal)
  );

endmodule

// File: rtl/agu_shadd_checker.sv
module agu_shadd_checker #(
  parameter int unsigned XLEN       = 64,
  parameter bit          BM_PRESENT = 1'b1,
  parameter int unsigned SH_W       = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [2:0]      in_op,
  input logic [XLEN-1:0] in_src1,
  input logic [XLEN-1:0] in_src2,
  input logic [SH_W-1:0] in_shamt,
  input logic            bm_enable,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result,
  input logic            out_illegal
);

  logic [XLEN-1:0] lo_src1;
  always_comb lo_src1 = {{(XLEN-32){1'b0}}, in_src1[31:0]};

  assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  assert_illegal_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0));

  assert_disabled_traps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !bm_enable) |=> (out_valid && out_illegal));

  assert_enabled_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && bm_enable && BM_PRESENT) |=> (out_valid && !out_illegal));

  assert_uw_scaled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && bm_enable && in_op[2] && (in_op[1:0] != 2'b00))
    |=> (out_result == ($past(in_src2) + ($past(lo_src1) << $past(in_op[1:0])))));

  wire unused_shamt = ^in_shamt;

endmodule

bind agu_shadd_unit agu_shadd_checker #(.XLEN(XLEN), .BM_PRESENT(BM_PRESENT), .SH_W(SH_W)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .in_src1     (in_src1),
  .in_src2     (in_src2),
  .in_shamt    (in_shamt),
  .bm_enable   (bm_enable),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/agu_shadd_unit_bench.sv
module agu_shadd_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'b000;
  logic [63:0] in_src1 = '0;
  logic [63:0] in_src2 = '0;
  logic [5:0]  in_shamt = '0;
  logic        bm_enable = 1'b1;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = !clk;

  agu_shadd_unit u_agu_shadd_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src1(in_src1), .in_src2(in_src2), .in_shamt(in_shamt),
    .bm_enable(bm_enable), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a,
                                        input logic [63:0] b, input logic [5:0] sh);
    logic [63:0] lo;
    lo = {32'h0, a[31:0]};
    case (op)
      3'b000:  return lo << sh;
      3'b100:  return lo + b;
      3'b001:  return b + (a << 1);
      3'b010:  return b + (a << 2);
      3'b011:  return b + (a << 3);
      3'b101:  return b + (lo << 1);
      3'b110:  return b + (lo << 2);
      default: return b + (lo << 3);
    endcase
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Send one operation with the consumer ready; check outputs one cycle later.
  task automatic run_op(input string req, input logic [2:0] op, input logic [63:0] a,
                        input logic [63:0] b, input logic [5:0] sh, input logic en);
    @(negedge clk);
    in_op = op; in_src1 = a; in_src2 = b; in_shamt = sh; bm_enable = en;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check64({req, " valid"}, {63'h0, out_valid}, 64'h1);
    check64({req, " illegal"}, {63'h0, out_illegal}, {63'h0, !en});
    check64({req, " result"}, out_result, en ? model(op, a, b, sh) : 64'h0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check64("R10 valid", {63'h0, out_valid}, 64'h0);
    check64("R10 illegal", {63'h0, out_illegal}, 64'h0);
    check64("R10 result", out_result, 64'h0);
  endtask

  task automatic t_scaled;
    run_op("R1 sh1add", 3'b001, 64'h0000_0000_0000_0010, 64'h0000_1000_0000_0000, 6'd0, 1'b1);
    run_op("R1 sh2add", 3'b010, 64'hFFFF_0000_0000_0003, 64'h0000_0000_0000_0100, 6'd9, 1'b1);
    run_op("R1 sh3add", 3'b011, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0007, 6'd63, 1'b1);
  endtask

  task automatic t_scaled_uw;
    run_op("R2 sh1add.uw", 3'b101, 64'hFFFF_FFFF_8000_0001, 64'h0000_0000_0000_1000, 6'd0, 1'b1);
    run_op("R2 sh2add.uw", 3'b110, 64'hDEAD_BEEF_0000_0004, 64'h0000_0000_0000_0000, 6'd5, 1'b1);
    run_op("R2 sh3add.uw", 3'b111, 64'h8000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 6'd0, 1'b1);
  endtask

  task automatic t_add_uw;
    run_op("R3 add.uw", 3'b100, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 6'd0, 1'b1);
    run_op("R3 zext.w", 3'b100, 64'hABCD_0123_8765_4321, 64'h0, 6'd17, 1'b1);
  endtask

  task automatic t_slli_uw;
    run_op("R4 slli.uw 0", 3'b000, 64'hFFFF_FFFF_8000_0001, 64'h5555_5555_5555_5555, 6'd0, 1'b1);
    run_op("R4 slli.uw 31", 3'b000, 64'hFFFF_FFFF_8000_0001, 64'h1, 6'd31, 1'b1);
    run_op("R4 slli.uw 63", 3'b000, 64'h0000_0000_0000_0003, 64'h0, 6'd63, 1'b1);
  endtask

  task automatic t_wrap;
    run_op("R5 wrap sh3add", 3'b011, 64'hF000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFF8, 6'd0, 1'b1);
    run_op("R5 wrap add.uw", 3'b100, 64'h0000_0000_0000_0002, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 1'b1);
  endtask

  task automatic t_disabled;
    run_op("R6 disabled sh2add", 3'b010, 64'h10, 64'h20, 6'd0, 1'b0);
    run_op("R6 disabled slli.uw", 3'b000, 64'hFFFF, 64'h0, 6'd4, 1'b0);
    run_op("R7 re-enabled", 3'b001, 64'h10, 64'h20, 6'd0, 1'b1);
  endtask

  task automatic t_backpressure;
    logic [63:0] first;
    first = model(3'b010, 64'h5, 64'h100, 6'd0);
    @(negedge clk);
    out_ready = 1'b0; bm_enable = 1'b1;
    in_op = 3'b010; in_src1 = 64'h5; in_src2 = 64'h100; in_valid = 1'b1;
    check64("R8 ready when empty", {63'h0, in_ready}, 64'h1);
    @(posedge clk);
    @(negedge clk);
    in_op = 3'b001; in_src1 = 64'h7; in_src2 = 64'h1;
    check64("R8 ready low when stalled", {63'h0, in_ready}, 64'h0);
    repeat (3) @(negedge clk);
    check64("R9 held valid", {63'h0, out_valid}, 64'h1);
    check64("R9 held result", out_result, first);
    out_ready = 1'b1;
    #1;
    check64("R8 ready with drain", {63'h0, in_ready}, 64'h1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check64("R8 replaced result", out_result, model(3'b001, 64'h7, 64'h1, 6'd0));
    @(negedge clk);
    check64("R8 drained", {63'h0, out_valid}, 64'h0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R8 actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_scaled();
    t_scaled_uw();
    t_add_uw();
    t_slli_uw();
    t_wrap();
    t_disabled();
    t_backpressure();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule